// File: doc/BRIEF.md
# Read-Capture Delay Window Calibration Engine

This engine tunes the delay setting used by the read-capture logic of a memory interface. On a start pulse it tries every delay setting in ascending order, beginning at zero. For each setting it writes a fixed set of pattern words to consecutive word addresses. It then reads each word back several times and compares every read with the pattern. A setting passes only if every one of its reads matches.

The first setting that passes opens the window. Failing settings seen before that are disregarded. The first failing setting after the window has opened closes it one step below that setting and ends the sweep at once. If nothing fails after the opening, the window extends to the highest setting.

The engine then drives the truncated mean of the window edges on its delay output and raises done. If no setting passed, it raises fail instead and drives the delay to zero. The memory and the capture path sit outside the block. They are reached through a request/acknowledge port, where the request is held until a one-cycle acknowledge completes the transfer.

Top module: `rdcal_engine`

## Requirements
- R1: After reset, dly_o is 0, done_o is 0, fail_o is 0 and mem_req_o is 0.
- R2: A start_i pulse while idle begins a sweep at delay 0, and each later candidate is the previous one plus 1. start_i has no effect while a sweep is running.
- R3: For every candidate the engine writes N_WORDS words to addresses 0, 1, … N_WORDS-1 in order. The value of word i (taken modulo 64) is set by g = i[5:4] and s = i[1] XOR i[3], and is a 16-bit value repeated across the data width:
  - g=0 gives 0x0000 when s=0 and 0xFFFF when s=1.
  - g=1 gives 0xAAAA when s=0 and 0x5555 when s=1.
  - g=2 gives 0xA5A5 when s=0 and 0x5A5A when s=1.
  - g=3 gives 0xAA55 when s=0 and 0x55AA when s=1.
- R4: dly_o takes the candidate value before that candidate's first write and keeps it until the candidate's last access completes.
- R5: After the writes, each address 0 … N_WORDS-1 is read N_READS times in a row, in address order. Every read is compared with that word's pattern.
- R6: The first mismatching read marks the candidate as failing. No further read is issued for that candidate.
- R7: Failing candidates before the first passing one are ignored, and the first passing candidate becomes the window start.
- R8: The first failing candidate after the window start sets the window end to that candidate minus 1. No higher candidate is then tried.
- R9: If no candidate fails after the window start, the sweep runs to the highest delay, and that highest delay is the window end.
- R10: When a window exists, the engine raises done_o with fail_o 0 and sets dly_o to floor((start+end)/2). done_o then stays high, with no requests issued, until the next start_i.
- R11: When no candidate passes, done_o and fail_o are raised and dly_o is 0.
- R12: Once mem_req_o is raised, it stays high with a stable address and direction until the cycle in which mem_ack_i is high. That cycle completes the transfer, and read data is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a calibration sweep when idle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Transfer completes in this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with mem_ack_i |
| dly_o | output | DLY_W | Capture delay: the candidate during the sweep, the result afterwards |
| done_o | output | 1 | Calibration finished |
| fail_o | output | 1 | No passing delay was found |

## Verification
Two events can fall in the same cycle.

The first is a candidate's pass verdict and a failure verdict at the very end of its read-back. The bench provokes this by letting the final repeated read of the final word mismatch at bad delays. It then judges that the window edges and the stop point are still exact.

The second is the window opening and the sweep ending together. The bench lets only the highest delay pass, so the start is recorded on the last candidate and the end defaults to that same value. It then expects exactly that delay, with fail low.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_EVAL,
        ST_FINISH
    } cal_state_t;

    localparam int PAT_IDX_W = 6;

endpackage

// File: rtl/rdcal_pattern.sv
module rdcal_pattern #(
    parameter int DATA_W = 32
) (
    input  logic [rdcal_pkg::PAT_IDX_W-1:0] idx_i,
    output logic [DATA_W-1:0]               word_o
);
    localparam int REP = DATA_W / 16;

    logic        pol;
    logic [15:0] base;

    always_comb begin
        pol = idx_i[1] ^ idx_i[3];
        unique case (idx_i[5:4])
            2'd0:    base = pol ? 16'hFFFF : 16'h0000;
            2'd1:    base = pol ? 16'h5555 : 16'hAAAA;
            2'd2:    base = pol ? 16'h5A5A : 16'hA5A5;
            default: base = pol ? 16'h55AA : 16'hAA55;
        endcase
        word_o = {REP{base}};
    end
endmodule

// File: rtl/rdcal_window.sv
module rdcal_window #(
    parameter int DLY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             verdict_v_i,
    input  logic             verdict_pass_i,
    input  logic [DLY_W-1:0] cand_i,
    output logic             found_o,
    output logic             closed_o,
    output logic [DLY_W-1:0] mean_o
);
    localparam logic [DLY_W-1:0] MAX_DLY = {DLY_W{1'b1}};

    typedef struct packed {
        logic             found;
        logic             closed;
        logic [DLY_W-1:0] lo;
        logic [DLY_W-1:0] hi;
    } win_t;

    win_t win_d, win_q;
    logic [DLY_W:0] sum;

    always_comb begin
        win_d = win_q;
        if (clear_i) begin
            win_d.found  = 1'b0;
            win_d.closed = 1'b0;
            win_d.lo     = '0;
            win_d.hi     = MAX_DLY;
        end else if (verdict_v_i) begin
            if (verdict_pass_i && !win_q.found) begin
                win_d.found = 1'b1;
                win_d.lo    = cand_i;
            end else if (!verdict_pass_i && win_q.found && !win_q.closed) begin
                win_d.closed = 1'b1;
                win_d.hi     = cand_i - 1'b1;
            end
        end
        sum = {1'b0, win_q.lo} + {1'b0, win_q.hi};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '{found: 1'b0, closed: 1'b0, lo: '0, hi: MAX_DLY};
        end else begin
            win_q <= win_d;
        end
    end

    assign found_o  = win_q.found;
    assign closed_o = win_q.closed;
    assign mean_o   = sum[DLY_W:1];
endmodule

// File: rtl/rdcal_ctrl.sv
module rdcal_ctrl
    import rdcal_pkg::*;
#(
    parameter int DLY_W   = 9,
    parameter int DATA_W  = 32,
    parameter int N_WORDS = 64,
    parameter int N_READS = 10,
    localparam int AW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int RW     = (N_READS > 1) ? $clog2(N_READS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 mem_ack_i,
    input  logic [DATA_W-1:0]    mem_rdata_i,
    input  logic [DATA_W-1:0]    pat_word_i,
    input  logic                 win_found_i,
    input  logic                 win_closed_i,
    input  logic [DLY_W-1:0]     win_mean_i,
    output logic                 mem_req_o,
    output logic                 mem_we_o,
    output logic [AW-1:0]        mem_addr_o,
    output logic [DATA_W-1:0]    mem_wdata_o,
    output logic [PAT_IDX_W-1:0] pat_idx_o,
    output logic                 win_clear_o,
    output logic                 verdict_v_o,
    output logic                 verdict_pass_o,
    output logic [DLY_W-1:0]     cand_o,
    output logic [DLY_W-1:0]     dly_o,
    output logic                 done_o,
    output logic                 fail_o
);
    localparam logic [DLY_W-1:0] MAX_DLY = {DLY_W{1'b1}};
    localparam logic [AW-1:0]    LAST_W  = AW'(N_WORDS - 1);
    localparam logic [RW-1:0]    LAST_R  = RW'(N_READS - 1);

    typedef struct packed {
        cal_state_t       state;
        logic [DLY_W-1:0] cand;
        logic [AW-1:0]    widx;
        logic [RW-1:0]    rcnt;
        logic [DLY_W-1:0] dly;
        logic             done;
        logic             fail;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d            = c_q;
        win_clear_o    = 1'b0;
        verdict_v_o    = 1'b0;
        verdict_pass_o = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    win_clear_o = 1'b1;
                    c_d.cand    = '0;
                    c_d.dly     = '0;
                    c_d.widx    = '0;
                    c_d.rcnt    = '0;
                    c_d.done    = 1'b0;
                    c_d.fail    = 1'b0;
                    c_d.state   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack_i) begin
                    if (c_q.widx == LAST_W) begin
                        c_d.widx  = '0;
                        c_d.rcnt  = '0;
                        c_d.state = ST_READ;
                    end else begin
                        c_d.widx = c_q.widx + 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack_i) begin
                    if (mem_rdata_i != pat_word_i) begin
                        verdict_v_o = 1'b1;
                        c_d.state   = ST_EVAL;
                    end else if (c_q.rcnt == LAST_R) begin
                        c_d.rcnt = '0;
                        if (c_q.widx == LAST_W) begin
                            verdict_v_o    = 1'b1;
                            verdict_pass_o = 1'b1;
                            c_d.state      = ST_EVAL;
                        end else begin
                            c_d.widx = c_q.widx + 1'b1;
                        end
                    end else begin
                        c_d.rcnt = c_q.rcnt + 1'b1;
                    end
                end
            end
            ST_EVAL: begin
                if (win_closed_i || (c_q.cand == MAX_DLY)) begin
                    c_d.state = ST_FINISH;
                end else begin
                    c_d.cand  = c_q.cand + 1'b1;
                    c_d.dly   = c_q.cand + 1'b1;
                    c_d.widx  = '0;
                    c_d.rcnt  = '0;
                    c_d.state = ST_WRITE;
                end
            end
            default: begin
                c_d.dly   = win_found_i ? win_mean_i : '0;
                c_d.fail  = !win_found_i;
                c_d.done  = 1'b1;
                c_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, cand: '0, widx: '0, rcnt: '0,
                     dly: '0, done: 1'b0, fail: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_req_o   = (c_q.state == ST_WRITE) || (c_q.state == ST_READ);
    assign mem_we_o    = (c_q.state == ST_WRITE);
    assign mem_addr_o  = c_q.widx;
    assign mem_wdata_o = pat_word_i;
    assign pat_idx_o   = PAT_IDX_W'(c_q.widx);
    assign cand_o      = c_q.cand;
    assign dly_o       = c_q.dly;
    assign done_o      = c_q.done;
    assign fail_o      = c_q.fail;
endmodule

// File: rtl/rdcal_engine.sv
module rdcal_engine #(
    parameter int DLY_W   = 9,
    parameter int DATA_W  = 32,
    parameter int N_WORDS = 64,
    parameter int N_READS = 10,
    localparam int AW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DLY_W-1:0]  dly_o,
    output logic              done_o,
    output logic              fail_o
);
    logic [rdcal_pkg::PAT_IDX_W-1:0] pat_idx;
    logic [DATA_W-1:0]               pat_word;
    logic                            win_clear, verdict_v, verdict_pass;
    logic                            win_found, win_closed;
    logic [DLY_W-1:0]                win_mean, cand;

    rdcal_pattern #(.DATA_W(DATA_W)) u_pat (
        .idx_i  (pat_idx),
        .word_o (pat_word)
    );

    rdcal_window #(.DLY_W(DLY_W)) u_win (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_i        (win_clear),
        .verdict_v_i    (verdict_v),
        .verdict_pass_i (verdict_pass),
        .cand_i         (cand),
        .found_o        (win_found),
        .closed_o       (win_closed),
        .mean_o         (win_mean)
    );

    rdcal_ctrl #(
        .DLY_W   (DLY_W),
        .DATA_W  (DATA_W),
        .N_WORDS (N_WORDS),
        .N_READS (N_READS)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .mem_ack_i      (mem_ack_i),
        .mem_rdata_i    (mem_rdata_i),
        .pat_word_i     (pat_word),
        .win_found_i    (win_found),
        .win_closed_i   (win_closed),
        .win_mean_i     (win_mean),
        .mem_req_o      (mem_req_o),
        .mem_we_o       (mem_we_o),
        .mem_addr_o     (mem_addr_o),
        .mem_wdata_o    (mem_wdata_o),
        .pat_idx_o      (pat_idx),
        .win_clear_o    (win_clear),
        .verdict_v_o    (verdict_v),
        .verdict_pass_o (verdict_pass),
        .cand_o         (cand),
        .dly_o          (dly_o),
        .done_o         (done_o),
        .fail_o         (fail_o)
    );
endmodule

// File: rtl/rdcal_checker.sv
module rdcal_checker #(
    parameter int DLY_W = 9,
    parameter int AW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic             mem_ack_i,
    input logic [DLY_W-1:0] dly_o,
    input logic             done_o,
    input logic             fail_o
);
    // R12: a pending request keeps its address and direction
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R4: no delay change while a transfer is still waiting
    p_dly_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> $stable(dly_o));

    // R11: failing calibration drives zero delay
    p_fail_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> (dly_o == '0));

    // R10: finished engine issues no requests
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

    // R2: candidates step upward by one during a sweep
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(done_o) && !$stable(dly_o) && (dly_o != '0))
        |-> (dly_o == DLY_W'($past(dly_o) + 1'b1)));
endmodule

bind rdcal_engine rdcal_checker #(.DLY_W(DLY_W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i),
    .dly_o      (dly_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
);

// File: tb/tb_rdcal_engine.sv
module tb_rdcal_engine;
    localparam int DLY_W = 4;
    localparam int DW    = 32;
    localparam int NW    = 64;
    localparam int NR    = 3;
    localparam int AW    = 6;
    localparam int MAXD  = (1 << DLY_W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            mem_req, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic            mem_ack = 1'b0;
    logic [DW-1:0]   mem_rdata = '0;
    logic [DLY_W-1:0] dly;
    logic            done, fail;

    always #2 clk = ~clk;

    rdcal_engine #(.DLY_W(DLY_W), .DATA_W(DW), .N_WORDS(NW), .N_READS(NR)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .dly_o(dly), .done_o(done), .fail_o(fail)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int cfg_lo, cfg_hi, cfg_bad;
    logic [DW-1:0] store [NW];
    int n_cand, cur_cand, last_cand, n_wr, n_rd;
    int order_err, stab_err, pat_err, rd_order_err, extra_rd, rd_on0, rd_on_lo;
    bit corrupted;

    function automatic logic [DW-1:0] exp_pat(int i);
        int g;
        bit s;
        g = (i / 16) % 4;
        s = ((i / 2) % 2) != ((i / 8) % 2);
        case (g)
            0: return s ? 32'hFFFF_FFFF : 32'h0000_0000;
            1: return s ? 32'h5555_5555 : 32'hAAAA_AAAA;
            2: return s ? 32'h5A5A_5A5A : 32'hA5A5_A5A5;
            default: return s ? 32'h55AA_55AA : 32'hAA55_AA55;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // memory and capture-path model, driven away from the rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                if (mem_addr == 0) begin
                    if (int'(dly) != ((n_cand == 0) ? 0 : cur_cand + 1)) order_err++;
                    cur_cand  = int'(dly);
                    last_cand = cur_cand;
                    n_cand++;
                    n_wr = 0;
                    n_rd = 0;
                    corrupted = 0;
                end
                if (int'(dly) != cur_cand) stab_err++;
                if (int'(mem_addr) != n_wr) pat_err++;
                if (mem_wdata != exp_pat(n_wr)) pat_err++;
                store[mem_addr] = mem_wdata;
                n_wr++;
            end else begin
                if (int'(dly) != cur_cand) stab_err++;
                if (corrupted) extra_rd++;
                if (int'(mem_addr) != n_rd / NR) rd_order_err++;
                mem_rdata = store[mem_addr];
                if ((int'(dly) < cfg_lo || int'(dly) > cfg_hi) && n_rd == cfg_bad) begin
                    mem_rdata = ~mem_rdata;
                    corrupted = 1;
                end
                n_rd++;
                if (cur_cand == 0) rd_on0 = n_rd;
                if (cur_cand == cfg_lo) rd_on_lo = n_rd;
            end
        end
    end

    task automatic run_case(int lo, int hi, int bad, bit poke, string name);
        int  cyc;
        bit  valid;
        int  exp_d, exp_last;
        cfg_lo = lo; cfg_hi = hi; cfg_bad = bad;
        n_cand = 0; cur_cand = 0; last_cand = -1; n_wr = 0; n_rd = 0;
        order_err = 0; stab_err = 0; pat_err = 0; rd_order_err = 0;
        extra_rd = 0; rd_on0 = 0; rd_on_lo = 0; corrupted = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 700) start = 1'b1;
            if (poke && cyc == 701) start = 1'b0;
        end
        check(cyc < 20000, "R10", {name, " watchdog"}, cyc, 20000);
        valid    = (lo <= hi);
        exp_d    = valid ? (lo + hi) / 2 : 0;
        exp_last = (valid && hi < MAXD) ? hi + 1 : MAXD;
        if (valid) begin
            check(done && !fail, "R10", {name, " done/fail"}, {done, fail}, 2);
            check(int'(dly) == exp_d, "R10", {name, " result delay"}, int'(dly), exp_d);
        end else begin
            check(done && fail, "R11", {name, " done/fail"}, {done, fail}, 3);
            check(int'(dly) == 0, "R11", {name, " delay"}, int'(dly), 0);
        end
        if (valid && hi < MAXD)
            check(last_cand == exp_last, "R8", {name, " last candidate"}, last_cand, exp_last);
        else
            check(last_cand == exp_last, "R9", {name, " last candidate"}, last_cand, exp_last);
        check(n_cand == exp_last + 1, "R2", {name, " candidate count"}, n_cand, exp_last + 1);
        check(order_err == 0, "R2", {name, " candidate order"}, order_err, 0);
        check(stab_err == 0, "R4", {name, " delay stability"}, stab_err, 0);
        check(pat_err == 0, "R3", {name, " write pattern/address"}, pat_err, 0);
        check(rd_order_err == 0, "R5", {name, " read order"}, rd_order_err, 0);
        check(extra_rd == 0, "R6", {name, " reads after mismatch"}, extra_rd, 0);
        if (lo > 0)
            check(rd_on0 == bad + 1, "R7", {name, " reads on failing delay 0"}, rd_on0, bad + 1);
        if (valid)
            check(rd_on_lo == NW * NR, "R5", {name, " reads on window start"}, rd_on_lo, NW * NR);
        repeat (5) @(negedge clk);
        check(done && !mem_req, "R10", {name, " done held, no request"}, {done, mem_req}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dly == 0 && !done && !fail && !mem_req, "R1", "reset state",
              {dly, done, fail, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dly == 0 && !done && !fail && !mem_req, "R1", "idle after reset",
              {dly, done, fail, mem_req}, 0);
        run_case(4, 10, 0, 0, "mid window");
        run_case(5, 8, NW * NR - 1, 0, "last repeated read");
        run_case(9, 15, 32, 0, "open to top");
        run_case(15, 15, 100, 0, "only top passes");
        run_case(0, 0, 5, 0, "only zero passes");
        run_case(1, 0, 2, 0, "nothing passes");
        run_case(3, 12, 1, 1, "start while busy");
        run_case(0, 14, 64, 0, "wide window");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R10 global watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule